// File: doc/BRIEF.md
# Monochrome Frame-Buffer Video Scanout

This block drives a built-in 512 by 342 monochrome panel, one bit per pixel, from a 15.6672 MHz dot clock (one dot is about 63.83 ns). It runs a fixed raster of 704 dots per line and 370 lines per frame. That gives a line rate near 22.25 kHz and a frame rate near 60.15 Hz, so one frame lasts about 16.626 ms. It produces active-low horizontal and vertical blanking and sync, a serial pixel stream, and a one-cycle frame-start pulse that can serve as a periodic interrupt.

Pixel data lives in shared main memory, in a fixed window that holds exactly one frame: 21,888 bytes starting at byte address 0x9F9A80. The block reads it through a request/grant port that returns one 16-bit word per grant. A one-word prefetch buffer sits between that port and a 16-bit serializer. The fetch pointer goes back to the window base when the last active line ends. Sharing memory with a processor is handled outside the block.

Top module: `mono_scanout`

## Requirements
- R1: Each line lasts H_TOTAL dots (default 704). `hblank_n` is high for the first H_ACTIVE dots (default 512) and low for the rest.
- R2: `hsync_n` is low for HS_WIDTH dots starting at dot HS_START of every line. That window always lies inside horizontal blanking.
- R3: Each frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines (default 342+0+4+24 = 370). `vblank_n` is high only during the V_ACTIVE displayed lines.
- R4: `vsync_n` is low for V_SYNC lines. It starts V_FRONT lines after the last displayed line (default 0, so it starts immediately) and is followed by V_BACK back-porch lines.
- R5: At displayed dot x of displayed line y, `pix_out` shows bit 15-(x mod 16) of the memory word at byte address BASE_ADDR + 2*(y*H_ACTIVE/16 + x/16). Bit 15 of each word is shown first, and 1 means a lit dot.
- R6: `pix_out` is 0 (black) whenever either blanking output is low.
- R7: Granted read addresses within a frame run BASE_ADDR, BASE_ADDR+2, and so on. There are exactly H_ACTIVE*V_ACTIVE/16 of them per frame, and the sequence starts again from BASE_ADDR every frame.
- R8: Once raised, `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_gnt` high. `mem_rdata` is taken in that same cycle.
- R9: `frame_start` is high for exactly one dot: the first dot of the first vertical-sync line.
- R10: While `rst_n` is low at a clock edge, the outputs become pixel 0, both blanking outputs low, both syncs high, `frame_start` low and `mem_req` low. The raster then restarts at dot 0 of the line just after the displayed area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Read request to shared memory |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_gnt | input | 1 | Grant; read data is valid in this cycle |
| mem_rdata | input | 16 | Word returned with the grant |
| pix_out | output | 1 | Serial pixel, 1 = lit |
| hblank_n | output | 1 | Horizontal blanking, active low |
| vblank_n | output | 1 | Vertical blanking, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| frame_start | output | 1 | One-dot pulse at the start of vertical sync |

## Verification
The embedded assertions check, on every cycle, the relations between outputs: each sync lies inside its blanking, the pixel is black during blanking, the frame pulse is a single dot inside vertical sync, and a pending request holds its address until granted. Only the bench's scenarios can show the absolute raster positions, the bit order and address-to-pixel mapping of the image, and the number of words fetched per frame. The bench checks these at every dot over several frames, using immediate, random and maximally late grants.

// File: rtl/mscan_pkg.sv
// Shared constants and types for the monochrome scanout block.
// Assumes the memory port always returns 16-bit words.
package mscan_pkg;
    localparam int WORD_BITS  = 16;
    localparam int WORD_BYTES = WORD_BITS / 8;
    typedef logic [WORD_BITS-1:0] word_t;
endpackage

// File: rtl/vid_raster.sv
// Raster timing generator: dot and line counters with registered
// active-low blanking and sync outputs and the frame-start pulse.
// Assumes HS_START >= H_ACTIVE and HS_START+HS_WIDTH <= H_TOTAL.
// After reset the raster starts at the first line below the displayed area.
module vid_raster
    import mscan_pkg::*;
#(
    parameter int H_ACTIVE = 512,
    parameter int H_TOTAL  = 704,
    parameter int HS_START = 526,
    parameter int HS_WIDTH = 178,
    parameter int V_ACTIVE = 342,
    parameter int V_FRONT  = 0,
    parameter int V_SYNC   = 4,
    parameter int V_BACK   = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic word_tick,
    output logic disp_active,
    output logic frame_restart,
    output logic hblank_n,
    output logic vblank_n,
    output logic hsync_n,
    output logic vsync_n,
    output logic frame_start
);
    localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int VS_START = V_ACTIVE + V_FRONT;
    localparam int HCW      = $clog2(H_TOTAL);
    localparam int VCW      = $clog2(V_TOTAL);
    localparam int SHW      = $clog2(WORD_BITS);

    logic [HCW-1:0] h_q;
    logic [VCW-1:0] v_q;
    logic line_end, frame_end, h_vis, v_vis, h_sync, v_sync, vs_first;

    // Decode the current raster position into regions.
    always_comb begin
        line_end      = (int'(h_q) == H_TOTAL - 1);
        frame_end     = (int'(v_q) == V_TOTAL - 1);
        h_vis         = (int'(h_q) < H_ACTIVE);
        v_vis         = (int'(v_q) < V_ACTIVE);
        h_sync        = (int'(h_q) >= HS_START) && (int'(h_q) < HS_START + HS_WIDTH);
        v_sync        = (int'(v_q) >= VS_START) && (int'(v_q) < VS_START + V_SYNC);
        vs_first      = (h_q == '0) && (int'(v_q) == VS_START);
        disp_active   = h_vis && v_vis;
        word_tick     = disp_active && (h_q[SHW-1:0] == '0);
        frame_restart = (h_q == '0) && (int'(v_q) == V_ACTIVE);
    end

    // Advance the dot counter, and the line counter at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= VCW'(V_ACTIVE);
        end else if (line_end) begin
            h_q <= '0;
            v_q <= frame_end ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    // Register the timing outputs, aligned with the serializer's pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hblank_n    <= 1'b0;
            vblank_n    <= 1'b0;
            hsync_n     <= 1'b1;
            vsync_n     <= 1'b1;
            frame_start <= 1'b0;
        end else begin
            hblank_n    <= h_vis;
            vblank_n    <= v_vis;
            hsync_n     <= !h_sync;
            vsync_n     <= !v_sync;
            frame_start <= vs_first;
        end
    end

    assert_hsync_in_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !hblank_n);
    assert_vsync_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !vblank_n);
    assert_pulse_in_vsync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!vsync_n && !vblank_n));
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (h_q == '0));
endmodule

// File: rtl/vid_fetch.sv
// Frame-buffer fetcher: walks the frame window one word at a time and
// keeps one prefetched word ready for the serializer.
// Assumes grants arrive within WORD_BITS dots of a request, and that
// 'restart' occurs only after every word of the frame has been fetched.
module vid_fetch
    import mscan_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter logic [23:0] BASE_ADDR   = 24'h9F9A80,
    parameter int          FRAME_WORDS = 10944
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  word_t             mem_rdata,
    output word_t             buf_word,
    output logic              buf_full
);
    localparam int                CW   = $clog2(FRAME_WORDS + 1);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [CW-1:0]     fetched_q;
    logic [ADDR_W-1:0] addr_q;
    logic              all_done, accept;

    // Request while the buffer is empty and the frame is not complete.
    always_comb begin
        all_done = (int'(fetched_q) == FRAME_WORDS);
        mem_req  = rst_n && !buf_full && !all_done;
        accept   = mem_req && mem_gnt;
        mem_addr = addr_q;
    end

    // Track the fetch pointer and fill or drain the one-word buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fetched_q <= '0;
            addr_q    <= BASE;
            buf_full  <= 1'b0;
            if (!rst_n) buf_word <= '0;
        end else if (accept) begin
            fetched_q <= fetched_q + 1'b1;
            addr_q    <= addr_q + STEP;
            buf_word  <= mem_rdata;
            buf_full  <= 1'b1;
        end else if (take) begin
            buf_full  <= 1'b0;
        end
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n || restart)
        accept |=> (mem_addr == $past(mem_addr) + STEP));
    assert_count_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fetched_q) <= FRAME_WORDS);
endmodule

// File: rtl/vid_serializer.sv
// Pixel serializer: loads a word at each word boundary and shifts it
// out most significant bit first; forces black outside the display area.
// Assumes 'load' only occurs during the displayed area.
module vid_serializer
    import mscan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  active,
    input  word_t word_in,
    output logic  pix
);
    word_t sh_q;

    // Shift one bit per dot and register the visible pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            pix  <= 1'b0;
        end else if (load) begin
            pix  <= word_in[WORD_BITS-1];
            sh_q <= {word_in[WORD_BITS-2:0], 1'b0};
        end else begin
            pix  <= active && sh_q[WORD_BITS-1];
            sh_q <= {sh_q[WORD_BITS-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mono_scanout.sv
// Monochrome frame-buffer scanout top: raster timing, frame-buffer
// fetch and pixel serializer. Assumes H_ACTIVE is a multiple of 16
// and that the memory grants requests promptly enough to keep one word ahead.
module mono_scanout
    import mscan_pkg::*;
#(
    parameter int          H_ACTIVE  = 512,
    parameter int          H_TOTAL   = 704,
    parameter int          HS_START  = 526,
    parameter int          HS_WIDTH  = 178,
    parameter int          V_ACTIVE  = 342,
    parameter int          V_FRONT   = 0,
    parameter int          V_SYNC    = 4,
    parameter int          V_BACK    = 24,
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] BASE_ADDR = 24'h9F9A80
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [15:0]       mem_rdata,
    output logic              pix_out,
    output logic              hblank_n,
    output logic              vblank_n,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              frame_start
);
    localparam int FRAME_WORDS = H_ACTIVE * V_ACTIVE / WORD_BITS;

    logic  word_tick, disp_active, frame_restart, buf_full;
    word_t buf_word;

    vid_raster #(
        .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
        .HS_START(HS_START), .HS_WIDTH(HS_WIDTH),
        .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT),
        .V_SYNC(V_SYNC),     .V_BACK(V_BACK)
    ) u_raster (
        .clk(clk), .rst_n(rst_n),
        .word_tick(word_tick), .disp_active(disp_active),
        .frame_restart(frame_restart),
        .hblank_n(hblank_n), .vblank_n(vblank_n),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .frame_start(frame_start)
    );

    vid_fetch #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .FRAME_WORDS(FRAME_WORDS)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .restart(frame_restart), .take(word_tick),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .buf_word(buf_word), .buf_full(buf_full)
    );

    vid_serializer u_ser (
        .clk(clk), .rst_n(rst_n),
        .load(word_tick), .active(disp_active),
        .word_in(buf_word), .pix(pix_out)
    );

    assert_black_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hblank_n || !vblank_n) |-> !pix_out);
    assert_no_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> !word_tick);
endmodule

// File: tb/test_mono_scanout.sv
// Self-checking bench for mono_scanout on a reduced raster.
module test_mono_scanout;
    localparam int          HA = 64, HT = 88, HSS = 70, HSW = 6;
    localparam int          VA = 10, VF = 0, VS = 2, VB = 3;
    localparam int          VT = VA + VF + VS + VB;
    localparam int          FW = HA * VA / 16;
    localparam int          FT = HT * VT;
    localparam logic [23:0] BASE = 24'h9F9A80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_gnt, pix_out, hblank_n, vblank_n, hsync_n, vsync_n, frame_start;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    mono_scanout #(
        .H_ACTIVE(HA), .H_TOTAL(HT), .HS_START(HSS), .HS_WIDTH(HSW),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
        .ADDR_W(24), .BASE_ADDR(BASE)
    ) i_mono_scanout (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .pix_out(pix_out),
        .hblank_n(hblank_n), .vblank_n(vblank_n), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .frame_start(frame_start)
    );

    function automatic logic [15:0] mem_word(input logic [23:0] a);
        return (a[15:0] * 16'h9E37) ^ {a[23:16], a[8:1]};
    endfunction

    function automatic logic exp_pixel(input int x, input int y);
        int          idx;
        logic [15:0] w;
        if (x >= HA || y >= VA) return 1'b0;
        idx = y * (HA / 16) + x / 16;
        w   = mem_word(BASE + 24'(2 * idx));
        return w[15 - (x % 16)];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int   g = 0, waits = 0, frames = 0;
        logic prev_pend = 1'b0;
        logic [23:0] prev_addr = '0;
        void'($urandom(32'd2024));
        mem_gnt   = 1'b0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 pix", 32'(pix_out), 0);
        chk("R10 hblank_n", 32'(hblank_n), 0);
        chk("R10 vblank_n", 32'(vblank_n), 0);
        chk("R10 hsync_n", 32'(hsync_n), 1);
        chk("R10 vsync_n", 32'(vsync_n), 1);
        chk("R10 frame_start", 32'(frame_start), 0);
        chk("R10 mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3 * FT + 40; k++) begin
            int x, y;
            logic gnt;
            @(negedge clk);
            x = k % HT;
            y = (VA + k / HT) % VT;
            chk("R1 hblank_n", 32'(hblank_n), 32'(x < HA));
            chk("R2 hsync_n", 32'(hsync_n), 32'(!(x >= HSS && x < HSS + HSW)));
            chk("R3 vblank_n", 32'(vblank_n), 32'(y < VA));
            chk("R4 vsync_n", 32'(vsync_n), 32'(!(y >= VA + VF && y < VA + VF + VS)));
            chk("R9 frame_start", 32'(frame_start), 32'(x == 0 && y == VA + VF));
            if (x < HA && y < VA) chk("R5 pixel", 32'(pix_out), 32'(exp_pixel(x, y)));
            else                  chk("R6 blank pixel", 32'(pix_out), 0);
            if (frame_start) begin
                if (frames > 0) chk("R7 words per frame", 32'(g), 32'(FW));
                g = 0;
                frames++;
            end
            if (prev_pend) begin
                chk("R8 request held", 32'(mem_req), 1);
                chk("R8 address stable", 32'(mem_addr), 32'(prev_addr));
            end
            gnt = 1'b0;
            if (mem_req) begin
                if (frames <= 1)      gnt = 1'b1;
                else if (frames == 2) gnt = ($urandom % 3 == 0) || (waits >= 6);
                else                  gnt = (waits >= 6);
            end
            if (gnt) begin
                chk("R7 address", 32'(mem_addr), 32'(BASE + 24'(2 * g)));
                mem_rdata = mem_word(mem_addr);
                g++;
                waits = 0;
            end else if (mem_req) begin
                waits++;
            end
            mem_gnt   = gnt;
            prev_pend = mem_req && !gnt;
            prev_addr = mem_addr;
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule